// File: doc/BRIEF.md
# Single-Wire Pulse-Count Setpoint Decoder

This block listens to one control line driven by a host processor and turns the number of low pulses in a burst into a regulator feedback setpoint. The line is brought into the local free-running clock domain through a two-flop synchroniser. A glitch filter then removes short spikes, and counters measure how long each high and low level lasts.

A burst starts with a long high level, carries one low pulse for each step, and ends with another long high level. When the closing high level has lasted long enough, a short settling delay runs and the pulse count is then committed as a 5-bit code. The code maps linearly to millivolts, from 800 mV up to 1250 mV in 15 mV steps. A long low level on the line returns the setpoint to its default of 800 mV at any time. All interval lengths are parameters counted in clock cycles.

Top module: `swire_setpoint_decoder`

## Requirements
- R1: After a synchronous reset, `code_o` is 0, `mv_o` is 800 and `busy_o` is 0.
- R2: A high level of at least START_CYC cycles, then N low pulses, then a high level of at least START_CYC cycles commits `code_o` = N. The two long high levels are the opening and closing intervals.
- R3: The committed code does not change until the closing high interval has been recognised and SETTLE_CYC further cycles have passed. `busy_o` is 1 from the first counted low edge until the commit.
- R4: A burst with more than 30 low pulses commits code 30, which is 1250 mV.
- R5: A low level held for at least OFF_CYC cycles sets `code_o` to 0 (800 mV) and ends any burst in progress.
- R6: With the line held permanently low, `code_o` stays 0 and `busy_o` stays 0.
- R7: A low or high level shorter than GLITCH_CYC cycles has no effect on the count.
- R8: Within a burst, a high level longer than a pulse phase but shorter than START_CYC, followed by a low edge, continues the count and does not commit.
- R9: Low pulses that are not preceded by a high interval of at least START_CYC cycles do not start a burst. They leave `code_o` and `busy_o` unchanged.
- R10: `mv_o` always equals 800 + 15 × `code_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Asynchronous single-wire control line |
| code_o | output | CODE_W | Committed pulse-count code |
| mv_o | output | MV_W | Committed setpoint in millivolts |
| busy_o | output | 1 | A burst is being counted or settling |

## Verification
A level change on the line reaches the interval counters after two synchroniser stages and GLITCH_CYC filter cycles, plus one more register. The commit therefore lands about 2 + GLITCH_CYC + START_CYC + SETTLE_CYC + 2 cycles after the closing rise, and a long low clears the code about 2 + GLITCH_CYC + OFF_CYC + 2 cycles after the fall. To keep clear of that boundary, each burst task samples twice. The first sample is 60 cycles after the closing rise, which is before the commit can land, and checks that the old code and a high busy flag are still present. The second sample is 85 cycles after the rise, after the latest commit time, and checks the new code, the millivolt value and a low busy flag. All samples are taken one time unit after a rising edge.

// File: rtl/swsp_pkg.sv
// Package: shared types for the single-wire setpoint decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package swsp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COUNT  = 2'd1,
        PH_SETTLE = 2'd2
    } phase_t;

    // Larger of two unsigned values, used for counter sizing.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swsp_sync.sv
// Two-flop synchroniser for the asynchronous control line.
// Assumes: line is idle low at reset.
module swsp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic stage1;

    // Shift the raw line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            dout   <= 1'b0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/swsp_deglitch.sv
// Level filter: the output follows the input only after the input has
// differed from it for FILT_CYC consecutive cycles.
// Assumes: FILT_CYC >= 1; output starts low.
module swsp_deglitch #(
    parameter int unsigned FILT_CYC = 20,
    localparam int unsigned CW = $clog2(FILT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    logic [CW-1:0] diff_cnt;

    // Count cycles of disagreement and flip once the filter time is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl      <= 1'b0;
            diff_cnt <= '0;
        end else if (din == lvl) begin
            diff_cnt <= '0;
        end else if (diff_cnt == CW'(FILT_CYC - 1)) begin
            lvl      <= din;
            diff_cnt <= '0;
        end else begin
            diff_cnt <= diff_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swsp_run_timer.sv
// Measures how long the filtered level has held, saturating at RUN_LIM.
// It also flags a falling edge of the filtered level.
// Assumes: RUN_LIM exceeds every threshold compared against run.
module swsp_run_timer #(
    parameter int unsigned RUN_LIM = 3001,
    localparam int unsigned RW = $clog2(RUN_LIM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl,
    output logic          lvl_q,
    output logic [RW-1:0] run,
    output logic          fall
);
    assign fall = lvl_q & ~lvl;

    // Track the previous level and the length of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run   <= '0;
        end else begin
            lvl_q <= lvl;
            if (lvl != lvl_q)
                run <= '0;
            else if (run != RW'(RUN_LIM))
                run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/swsp_burst_fsm.sv
// Burst framing and commit logic. The burst is armed by a long high level
// and counts falling edges, saturating at MAX_CODE. A long high level
// closes the burst, and the code is committed SETTLE_CYC cycles later.
// A long low level clears the code from any phase.
// Assumes: START_CYC, OFF_CYC < 2**RW - 1 and SETTLE_CYC >= 1.
module swsp_burst_fsm
    import swsp_pkg::*;
#(
    parameter int unsigned CODE_W     = 5,
    parameter int unsigned MAX_CODE   = 30,
    parameter int unsigned START_CYC  = 3000,
    parameter int unsigned OFF_CYC    = 2700,
    parameter int unsigned SETTLE_CYC = 200,
    parameter int unsigned RW         = 12,
    localparam int unsigned SW = $clog2(SETTLE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_q,
    input  logic [RW-1:0]     run,
    input  logic              fall,
    output logic [CODE_W-1:0] code,
    output logic              busy
);
    phase_t            phase;
    logic [CODE_W-1:0] cnt;
    logic [SW-1:0]     settle;
    logic              long_high;
    logic              long_low;
    logic              armed_fall;

    assign long_high  = lvl_q & (run == RW'(START_CYC));
    assign long_low   = ~lvl_q & (run == RW'(OFF_CYC));
    assign armed_fall = fall & (run >= RW'(START_CYC));
    assign busy       = (phase != PH_IDLE);

    // Phase sequencing, pulse counting and delayed commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            settle <= '0;
            code   <= '0;
        end else if (long_low) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            code  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (armed_fall) begin
                        phase <= PH_COUNT;
                        cnt   <= CODE_W'(1);
                    end
                end
                PH_COUNT: begin
                    if (fall) begin
                        if (cnt < CODE_W'(MAX_CODE))
                            cnt <= cnt + 1'b1;
                    end else if (long_high) begin
                        phase  <= PH_SETTLE;
                        settle <= '0;
                    end
                end
                PH_SETTLE: begin
                    if (settle == SW'(SETTLE_CYC - 1)) begin
                        code  <= cnt;
                        phase <= PH_IDLE;
                    end else begin
                        settle <= settle + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swire_setpoint_decoder.sv
// Top: single-wire pulse-count setpoint decoder. The path is synchroniser,
// glitch filter, run timer, then burst state machine. The committed code
// is mapped to millivolts as BASE_MV + STEP_MV * code.
// Assumes: the clock is free running; all intervals are given in cycles.
module swire_setpoint_decoder
    import swsp_pkg::*;
#(
    parameter int unsigned CODE_W     = 5,
    parameter int unsigned MAX_CODE   = 30,
    parameter int unsigned BASE_MV    = 800,
    parameter int unsigned STEP_MV    = 15,
    parameter int unsigned GLITCH_CYC = 20,
    parameter int unsigned START_CYC  = 3000,
    parameter int unsigned OFF_CYC    = 2700,
    parameter int unsigned SETTLE_CYC = 200,
    localparam int unsigned MV_W    = $clog2(BASE_MV + STEP_MV * MAX_CODE + 1),
    localparam int unsigned RUN_LIM = umax(START_CYC, OFF_CYC) + 1,
    localparam int unsigned RW      = $clog2(RUN_LIM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic [CODE_W-1:0] code_o,
    output logic [MV_W-1:0]   mv_o,
    output logic              busy_o
);
    logic          line_s;
    logic          line_f;
    logic          lvl_q;
    logic [RW-1:0] run;
    logic          fall;

    swsp_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_i),
        .dout (line_s)
    );

    swsp_deglitch #(.FILT_CYC(GLITCH_CYC)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_s),
        .lvl  (line_f)
    );

    swsp_run_timer #(.RUN_LIM(RUN_LIM)) u_run (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (line_f),
        .lvl_q(lvl_q),
        .run  (run),
        .fall (fall)
    );

    swsp_burst_fsm #(
        .CODE_W    (CODE_W),
        .MAX_CODE  (MAX_CODE),
        .START_CYC (START_CYC),
        .OFF_CYC   (OFF_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .RW        (RW)
    ) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_q(lvl_q),
        .run  (run),
        .fall (fall),
        .code (code_o),
        .busy (busy_o)
    );

    // Linear code-to-millivolt mapping.
    assign mv_o = MV_W'(32'(BASE_MV) + 32'(STEP_MV) * 32'(code_o));
endmodule

// File: rtl/swsp_checker.sv
// Assertion checker bound to the decoder top; it observes ports only.
module swsp_checker #(
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned MAX_CODE = 30,
    parameter int unsigned BASE_MV  = 800,
    parameter int unsigned STEP_MV  = 15,
    parameter int unsigned MV_W     = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code,
    input logic [MV_W-1:0]   mv,
    input logic              busy
);
    // R1: reset drives the default state on the following edge.
    p_reset_default_r1: assert property (@(posedge clk)
        !rst_n |=> (code == '0 && !busy));

    // R4: the committed code never exceeds the saturation value.
    p_code_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code <= CODE_W'(MAX_CODE));

    // R3: a nonzero code appears only at the end of a busy burst.
    p_commit_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(code) && code != '0) |-> $past(busy));

    // R9 and R5: while idle, the code either holds or clears to zero.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !busy) |-> (code == $past(code) || code == '0));

    // R10: the millivolt output stays in range and is the default exactly at code zero.
    p_mv_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mv >= MV_W'(BASE_MV)) && (mv <= MV_W'(BASE_MV + STEP_MV * MAX_CODE)) &&
        ((code == '0) == (mv == MV_W'(BASE_MV))));
endmodule

bind swire_setpoint_decoder swsp_checker #(
    .CODE_W  (CODE_W),
    .MAX_CODE(MAX_CODE),
    .BASE_MV (BASE_MV),
    .STEP_MV (STEP_MV),
    .MV_W    (MV_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .code (code_o),
    .mv   (mv_o),
    .busy (busy_o)
);

// File: tb/tb_swire_setpoint_decoder.sv
// Directed bench for the single-wire setpoint decoder, one task per scenario.
module tb_swire_setpoint_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int GLITCH = 3;
    localparam int START  = 60;
    localparam int OFF    = 50;
    localparam int SETTLE = 6;
    localparam int PH     = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b0;
    logic [4:0]  code;
    logic [10:0] mv;
    logic        busy;

    int nchk = 0;
    int nfail = 0;
    int model_code = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swire_setpoint_decoder #(
        .GLITCH_CYC(GLITCH),
        .START_CYC (START),
        .OFF_CYC   (OFF),
        .SETTLE_CYC(SETTLE)
    ) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(line),
        .code_o(code),
        .mv_o  (mv),
        .busy_o(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int cyc);
        line = v;
        repeat (cyc) @(posedge clk);
        #1;
    endtask

    task automatic idle(input int cyc);
        repeat (cyc) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // Opening interval, n low pulses, closing interval; checks R3 then R2/R10.
    task automatic run_burst(input int n, input int gap_idx, input int gap_len,
                             input bit glitchy, input int exp, input string tag);
        int expected_mv;
        if (glitchy) begin
            drive(1, 30); drive(0, 1); drive(1, 39);
        end else begin
            drive(1, START + 10);
        end
        for (int i = 0; i < n; i++) begin
            if (glitchy) begin
                drive(0, 4); drive(1, 1); drive(0, 5);
            end else begin
                drive(0, PH);
            end
            if (i < n - 1) begin
                if (i == gap_idx) drive(1, gap_len);
                else if (glitchy) begin
                    drive(1, 4); drive(0, 1); drive(1, 5);
                end else drive(1, PH);
            end
        end
        line = 1'b1;
        idle(60);
        check({tag, " R3 code held before settle"}, int'(code), model_code);
        check({tag, " R3 busy during burst"}, int'(busy), 1);
        idle(25);
        model_code = exp;
        expected_mv = 800 + 15 * exp;
        check({tag, " R2 committed code"}, int'(code), exp);
        check({tag, " R10 millivolts"}, int'(mv), expected_mv);
        check({tag, " R3 busy cleared"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        idle(1);
        check("R1 code", int'(code), 0);
        check("R1 mv", int'(mv), 800);
        check("R1 busy", int'(busy), 0);
    endtask

    task automatic t_tied_low();
        drive(0, 200);
        check("R6 code low line", int'(code), 0);
        check("R6 busy low line", int'(busy), 0);
    endtask

    task automatic t_long_low();
        drive(0, 70);
        model_code = 0;
        check("R5 code cleared", int'(code), 0);
        check("R5 mv default", int'(mv), 800);
        check("R5 busy cleared", int'(busy), 0);
    endtask

    task automatic t_no_start();
        for (int i = 0; i < 3; i++) begin
            drive(1, 20);
            drive(0, PH);
            check("R9 busy without start", int'(busy), 0);
        end
        drive(1, 100);
        check("R9 code unchanged", int'(code), 0);
        check("R9 busy idle", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_tied_low();
        run_burst(5, -1, 0, 1'b0, 5, "burst5");
        run_burst(30, -1, 0, 1'b0, 30, "burst30");
        run_burst(34, -1, 0, 1'b0, 30, "R4 saturate");
        run_burst(3, -1, 0, 1'b1, 3, "R7 glitches");
        run_burst(4, 1, 40, 1'b0, 4, "R8 medium gap");
        t_long_low();
        t_no_start();
        finish_run();
    end
endmodule